// File: doc/BRIEF.md
# Boot-Side Selectable Block Map and Write Permission Gate

This block sits between the command logic of a flash array controller and the array itself. For a 22-bit word address it reports which erase block and which protection group the word falls in. It also flags whether the word lies in the small parameter region. It then decides, without any clock delay, whether a program or erase aimed at that block may go ahead. The decision weighs three things: the level seen on the write-protect pin, a high-voltage level on the reset pin, and a vector holding one stored protection bit per group.

The array has 135 erase blocks. There are 127 main blocks of 32K words and 8 parameter blocks of 4K words. Together the 8 parameter blocks fill one 32K-word slot. A strap input selects whether that slot sits at the top or at the bottom of the address space. Block numbers always grow with the address. The parameter slot has its own protection group. The main blocks are grouped by 128K-word chunk, so the chunk shared with the parameter slot holds only three main blocks.

A second channel answers protection-status reads. A request carries an address. The response returns one byte telling whether that address's group is marked protected. Both sides use valid/ready. The request is accepted whenever the single response register is empty or is being drained in the same cycle. A stalled response keeps its valid and data unchanged until it is taken.

Top module: `blkmap_guard`

## Requirements
- R1: With the strap low (bottom boot), words 0..32767 map to blocks 0..7 in 4K-word steps. Any other address maps to block 7 + (addr >> 15), so the top address 0x3FFFFF maps to block 134.
- R2: With the strap high (top boot), addresses below 0x3F8000 map to block addr >> 15, covering 0..126. The top 32K words map to blocks 127..134 in 4K-word steps.
- R3: Group index, bottom boot: the parameter slot is group 0, and any other address is group (addr >> 17) + 1. Top boot: any address outside the parameter slot is group addr >> 17, and the parameter slot is group 32. The group bit used is bit [group] of the protection vector.
- R4: The boot flag is 1 exactly when the address falls in the parameter slot of the selected boot side.
- R5: The write-protect pin is encoded 2'b00 low, 2'b01 high, 2'b10 high voltage, and 2'b11 behaves as high. When it is low, the two outermost parameter blocks are denied, whatever their group bit and the reset level. The outermost blocks are 0 and 1 for bottom boot, and 133 and 134 for top boot.
- R6: With write protect at high voltage, every block is allowed, whatever the group bits.
- R7: With reset at the high-voltage level (reset level input = 1) and write protect not at high voltage, every block is allowed except the case denied by R5.
- R8: Otherwise (write protect high or reserved, or low on a block outside the outermost two, and reset normal), a block is allowed exactly when its group bit is 0.
- R9: A status request accepted on a clock edge shows a response from the next cycle. The response byte is 8'h01 if the requested address's group bit was 1 at acceptance, and 8'h00 if not. The pin levels have no effect on it.
- R10: The request ready equals (no response pending) or (response ready). A response that is valid but not taken keeps valid high and data unchanged.
- R11: During and right after reset, the response valid is low and the request ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| top_boot | input | 1 | Boot side strap, 1 = parameter slot at the top |
| addr | input | 22 | Word address under decision |
| grp_prot | input | 33 | Stored protection bit per group |
| wp_lvl | input | 2 | Encoded write-protect pin level |
| rst_hv | input | 1 | Reset pin at the high-voltage level |
| blk_idx | output | 8 | Erase block index of addr |
| grp_idx | output | 6 | Protection group index of addr |
| is_boot | output | 1 | addr lies in the parameter slot |
| wr_ok | output | 1 | Program or erase of addr allowed |
| st_req_valid | input | 1 | Status request valid |
| st_req_ready | output | 1 | Status request ready |
| st_req_addr | input | 22 | Address whose group status is asked |
| st_rsp_valid | output | 1 | Status response valid |
| st_rsp_ready | input | 1 | Status response ready |
| st_rsp_data | output | 8 | Status byte, 01h protected, 00h not |

## Verification
The bench drives the edges of the parameter slot on both boot sides. These are word 0x7FFF against 0x8000 and 0x3F7FFF against 0x3F8000. A decoder with the wrong side or an off-by-one offset would number block 7 or 127 wrongly and shift every main group by one. The bench sweeps the pin levels against all-ones and all-zeros protection vectors. A gate with the wrong precedence would let the high-voltage reset level open the outermost blocks while write protect is low. A gate that handled only three pin codes would treat the reserved code 2'b11 like low. The status channel runs with back-pressure toggled at random. A response register that reloaded while stalled would change its data, or lose a request, in the same cycle.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
  typedef enum logic [1:0] {
    WP_LOW  = 2'b00,
    WP_HIGH = 2'b01,
    WP_HV   = 2'b10,
    WP_RSVD = 2'b11
  } wp_lvl_e;

  localparam logic [7:0] ST_PROT   = 8'h01;
  localparam logic [7:0] ST_UNPROT = 8'h00;
endpackage

// File: rtl/blkmap_decode.sv
module blkmap_decode #(
  parameter int ADDR_W      = 22,
  parameter int PARAM_SHIFT = 12,
  parameter int MAIN_SHIFT  = 15,
  parameter int GROUP_SHIFT = 17,
  parameter int BLK_W       = 8,
  parameter int GRP_W       = 6
) (
  input  logic              top_boot,
  input  logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  blk,
  output logic [GRP_W-1:0]  grp,
  output logic              in_param,
  output logic              outer
);
  localparam int HI_W   = ADDR_W - MAIN_SHIFT;
  localparam int SUB_W  = MAIN_SHIFT - PARAM_SHIFT;
  localparam int CH_W   = ADDR_W - GROUP_SHIFT;
  localparam int NPARAM = 1 << SUB_W;
  localparam int NMAIN  = (1 << HI_W) - 1;
  localparam int NGRP   = (1 << CH_W) + 1;

  logic [HI_W-1:0]  hi;
  logic [SUB_W-1:0] sub;
  logic [CH_W-1:0]  chunk;

  assign hi    = addr[ADDR_W-1:MAIN_SHIFT];
  assign sub   = addr[MAIN_SHIFT-1:PARAM_SHIFT];
  assign chunk = addr[ADDR_W-1:GROUP_SHIFT];

  always_comb begin
    in_param = top_boot ? (&hi) : (hi == '0);
    if (in_param) begin
      blk   = top_boot ? (BLK_W'(NMAIN) + BLK_W'(sub)) : BLK_W'(sub);
      grp   = top_boot ? GRP_W'(NGRP - 1) : '0;
      outer = top_boot ? (sub >= SUB_W'(NPARAM - 2)) : (sub < SUB_W'(2));
    end else begin
      blk   = top_boot ? BLK_W'(hi) : (BLK_W'(hi) + BLK_W'(NPARAM - 1));
      grp   = top_boot ? GRP_W'(chunk) : (GRP_W'(chunk) + GRP_W'(1));
      outer = 1'b0;
    end
  end
endmodule

// File: rtl/blkmap_wrgate.sv
module blkmap_wrgate
  import blkmap_pkg::*;
(
  input  logic [1:0] wp_lvl,
  input  logic       rst_hv,
  input  logic       outer,
  input  logic       grp_bit,
  output logic       ok
);
  always_comb begin
    if (wp_lvl == WP_HV)                ok = 1'b1;
    else if (wp_lvl == WP_LOW && outer) ok = 1'b0;
    else if (rst_hv)                    ok = 1'b1;
    else                                ok = ~grp_bit;
  end
endmodule

// File: rtl/blkmap_status.sv
module blkmap_status
  import blkmap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_bit,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data
);
  assign req_ready = ~rsp_valid | rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= ST_UNPROT;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_data <= req_bit ? ST_PROT : ST_UNPROT;
    end
  end

  // R10: a stalled response holds valid and data
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9: only the two legal codes appear
  p_rsp_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[7:1] == 7'd0));

  // R9: an accepted request yields a response next cycle
  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: rtl/blkmap_guard.sv
module blkmap_guard
  import blkmap_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int PARAM_SHIFT = 12,
  parameter int MAIN_SHIFT  = 15,
  parameter int GROUP_SHIFT = 17,
  parameter int NUM_PARAM   = 1 << (MAIN_SHIFT - PARAM_SHIFT),
  parameter int NUM_MAIN    = (1 << (ADDR_W - MAIN_SHIFT)) - 1,
  parameter int NUM_BLK     = NUM_MAIN + NUM_PARAM,
  parameter int NUM_GRP     = (1 << (ADDR_W - GROUP_SHIFT)) + 1,
  parameter int BLK_W       = $clog2(NUM_BLK),
  parameter int GRP_W       = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               top_boot,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_GRP-1:0] grp_prot,
  input  logic [1:0]         wp_lvl,
  input  logic               rst_hv,
  output logic [BLK_W-1:0]   blk_idx,
  output logic [GRP_W-1:0]   grp_idx,
  output logic               is_boot,
  output logic               wr_ok,
  input  logic               st_req_valid,
  output logic               st_req_ready,
  input  logic [ADDR_W-1:0]  st_req_addr,
  output logic               st_rsp_valid,
  input  logic               st_rsp_ready,
  output logic [7:0]         st_rsp_data
);
  logic             outer_w;
  logic [BLK_W-1:0] sq_blk;
  logic [GRP_W-1:0] sq_grp;
  logic             sq_param, sq_outer;

  blkmap_decode #(
    .ADDR_W(ADDR_W), .PARAM_SHIFT(PARAM_SHIFT), .MAIN_SHIFT(MAIN_SHIFT),
    .GROUP_SHIFT(GROUP_SHIFT), .BLK_W(BLK_W), .GRP_W(GRP_W)
  ) u_dec (
    .top_boot(top_boot), .addr(addr), .blk(blk_idx), .grp(grp_idx),
    .in_param(is_boot), .outer(outer_w)
  );

  blkmap_wrgate u_gate (
    .wp_lvl(wp_lvl), .rst_hv(rst_hv), .outer(outer_w),
    .grp_bit(grp_prot[grp_idx]), .ok(wr_ok)
  );

  blkmap_decode #(
    .ADDR_W(ADDR_W), .PARAM_SHIFT(PARAM_SHIFT), .MAIN_SHIFT(MAIN_SHIFT),
    .GROUP_SHIFT(GROUP_SHIFT), .BLK_W(BLK_W), .GRP_W(GRP_W)
  ) u_sdec (
    .top_boot(top_boot), .addr(st_req_addr), .blk(sq_blk), .grp(sq_grp),
    .in_param(sq_param), .outer(sq_outer)
  );

  blkmap_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .req_valid(st_req_valid), .req_ready(st_req_ready),
    .req_bit(grp_prot[sq_grp]),
    .rsp_valid(st_rsp_valid), .rsp_ready(st_rsp_ready), .rsp_data(st_rsp_data)
  );

  // R1/R2: index stays inside the block count
  p_blk_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(blk_idx) < NUM_BLK);

  // R4: boot flag agrees with the side the strap selects
  p_boot_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_boot |-> (top_boot ? (int'(blk_idx) >= NUM_MAIN) : (int'(blk_idx) < NUM_PARAM)));

  // R5: outermost blocks locked while write protect is low
  p_wp_low_outer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_lvl == WP_LOW && outer_w) |-> !wr_ok);

  // R6: high voltage on write protect opens every block
  p_wp_hv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_lvl == WP_HV) |-> wr_ok);

  // R7: high-voltage reset opens everything but the R5 case
  p_rst_hv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_hv && !(wp_lvl == WP_LOW && outer_w)) |-> wr_ok);

  // R3: group index never leaves the vector
  p_grp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(grp_idx) < NUM_GRP);
endmodule

// File: tb/tb_blkmap_guard.sv
module tb_blkmap_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        top_boot;
  logic [21:0] addr;
  logic [32:0] grp_prot;
  logic [1:0]  wp_lvl;
  logic        rst_hv;
  logic [7:0]  blk_idx;
  logic [5:0]  grp_idx;
  logic        is_boot, wr_ok;
  logic        st_req_valid, st_req_ready, st_rsp_valid, st_rsp_ready;
  logic [21:0] st_req_addr;
  logic [7:0]  st_rsp_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit m_vld = 0;
  int m_dat = 0;

  always #5 clk = ~clk;

  blkmap_guard dut (
    .clk(clk), .rst_n(rst_n), .top_boot(top_boot), .addr(addr),
    .grp_prot(grp_prot), .wp_lvl(wp_lvl), .rst_hv(rst_hv),
    .blk_idx(blk_idx), .grp_idx(grp_idx), .is_boot(is_boot), .wr_ok(wr_ok),
    .st_req_valid(st_req_valid), .st_req_ready(st_req_ready),
    .st_req_addr(st_req_addr), .st_rsp_valid(st_rsp_valid),
    .st_rsp_ready(st_rsp_ready), .st_rsp_data(st_rsp_data)
  );

  function automatic int f_blk(bit top, int a);
    int slot = a / 32768;
    int s = (a % 32768) / 4096;
    if (!top) return (slot == 0) ? s : slot + 7;
    return (slot == 127) ? 127 + s : slot;
  endfunction

  function automatic int f_grp(bit top, int a);
    int slot = a / 32768;
    if (!top) return (slot == 0) ? 0 : a / 131072 + 1;
    return (slot == 127) ? 32 : a / 131072;
  endfunction

  function automatic bit f_boot(bit top, int a);
    return top ? (a / 32768 == 127) : (a / 32768 == 0);
  endfunction

  function automatic bit f_ok(bit top, int a, logic [32:0] pv, int wp, bit hv);
    int b = f_blk(top, a);
    bit edge_blk = top ? (b >= 133) : (b <= 1);
    if (wp == 2) return 1;
    if (wp == 0 && edge_blk) return 0;
    if (hv) return 1;
    return !pv[f_grp(top, a)];
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model, then advance the model by one edge
  task automatic cyc();
    bit nv;
    int nd;
    #1;
    chk("R1/R2 blk", int'(blk_idx), f_blk(top_boot, int'(addr)));
    chk("R3 grp", int'(grp_idx), f_grp(top_boot, int'(addr)));
    chk("R4 boot", int'(is_boot), int'(f_boot(top_boot, int'(addr))));
    chk("R5-R8 wr_ok", int'(wr_ok),
        int'(f_ok(top_boot, int'(addr), grp_prot, int'(wp_lvl), rst_hv)));
    chk("R10 ready", int'(st_req_ready), int'(!m_vld || st_rsp_ready));
    chk("R9 rsp_valid", int'(st_rsp_valid), int'(m_vld));
    if (m_vld) chk("R9 rsp_data", int'(st_rsp_data), m_dat);
    nv = m_vld; nd = m_dat;
    if (!m_vld || st_rsp_ready) begin
      nv = st_req_valid;
      if (st_req_valid) nd = grp_prot[f_grp(top_boot, int'(st_req_addr))] ? 1 : 0;
    end
    @(posedge clk);
    m_vld = nv; m_dat = nd;
    @(negedge clk);
  endtask

  task automatic dir(bit top, int a, int eb, int eg, int ebt, string tag);
    top_boot = top; addr = a[21:0];
    #1;
    chk({tag, " blk"}, int'(blk_idx), eb);
    chk({tag, " grp"}, int'(grp_idx), eg);
    chk({tag, " boot"}, int'(is_boot), ebt);
    cyc();
  endtask

  task automatic perm(bit top, int a, int wp, bit hv, logic [32:0] pv, int exp, string tag);
    top_boot = top; addr = a[21:0]; wp_lvl = wp[1:0]; rst_hv = hv; grp_prot = pv;
    #1;
    chk(tag, int'(wr_ok), exp);
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (completion)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; top_boot = 0; addr = '0; grp_prot = '0; wp_lvl = 2'b01;
    rst_hv = 0; st_req_valid = 0; st_req_addr = '0; st_rsp_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 rsp_valid in reset", int'(st_rsp_valid), 0);
    chk("R11 ready in reset", int'(st_req_ready), 1);
    rst_n = 1;
    #1;
    chk("R11 rsp_valid after reset", int'(st_rsp_valid), 0);
    @(negedge clk);

    // R1 bottom boot map
    dir(0, 'h000000,   0,  0, 1, "R1 a0");
    dir(0, 'h001000,   1,  0, 1, "R1 a1000");
    dir(0, 'h007FFF,   7,  0, 1, "R1 a7fff");
    dir(0, 'h008000,   8,  1, 0, "R1 a8000");
    dir(0, 'h020000,  11,  2, 0, "R1 a20000");
    dir(0, 'h3FFFFF, 134, 32, 0, "R1 top");
    // R2 top boot map
    dir(1, 'h000000,   0,  0, 0, "R2 a0");
    dir(1, 'h3F7FFF, 126, 31, 0, "R2 a3f7fff");
    dir(1, 'h3F8000, 127, 32, 1, "R2 a3f8000");
    dir(1, 'h3FFFFF, 134, 32, 1, "R2 top");

    // R5: low write protect wins over high-voltage reset
    perm(0, 'h001000, 0, 1, '0, 0, "R5 bottom blk1");
    perm(0, 'h002000, 0, 1, '1, 1, "R5/R7 bottom blk2 open");
    perm(1, 'h3FE000, 0, 1, '0, 0, "R5 top blk133");
    perm(1, 'h3FD000, 0, 0, '0, 1, "R5 top blk132 open");
    // R6
    perm(0, 'h000000, 2, 0, '1, 1, "R6 blk0 all protected");
    perm(1, 'h100000, 2, 0, '1, 1, "R6 main all protected");
    // R7
    perm(0, 'h200000, 1, 1, '1, 1, "R7 rst hv");
    perm(1, 'h3FF000, 1, 1, '1, 1, "R7 top edge wp high");
    // R8
    perm(0, 'h020000, 1, 0, 33'h4, 0, "R8 grp2 protected");
    perm(0, 'h040000, 1, 0, 33'h4, 1, "R8 grp3 open");
    perm(0, 'h020000, 3, 0, 33'h4, 0, "R8 reserved acts high");
    perm(0, 'h000000, 3, 0, 33'h0, 1, "R8 reserved edge open");

    // R9: literal status responses, pins set to opposite extremes
    grp_prot = 33'h1; wp_lvl = 2'b10; rst_hv = 1;
    st_rsp_ready = 1; st_req_valid = 1; top_boot = 0; st_req_addr = 22'h000000;
    cyc();
    st_req_addr = 22'h040000;
    #1;
    chk("R9 protected code", int'(st_rsp_data), 1);
    cyc();
    st_req_valid = 0;
    #1;
    chk("R9 unprotected code", int'(st_rsp_data), 0);
    cyc();
    // R10: stall holds
    st_req_valid = 1; st_rsp_ready = 0; st_req_addr = 22'h000000;
    cyc();
    st_req_addr = 22'h040000;
    cyc();
    #1;
    chk("R10 held data", int'(st_rsp_data), 1);
    chk("R10 not ready", int'(st_req_ready), 0);
    cyc();

    // random traffic, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      top_boot = 1'($urandom);
      case ($urandom % 4)
        0: addr = 22'($urandom % 65536);
        1: addr = 22'h3F0000 | 22'($urandom % 65536);
        default: addr = 22'($urandom);
      endcase
      grp_prot = {1'($urandom), 32'($urandom)};
      wp_lvl = 2'($urandom);
      rst_hv = 1'($urandom);
      st_req_valid = 1'($urandom);
      st_req_addr = ($urandom % 3 == 0) ? 22'($urandom % 40000) : 22'($urandom);
      st_rsp_ready = 1'($urandom);
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule